// File: doc/BRIEF.md
# Nibble-Multiplexed Chroma Demultiplexer

This block rebuilds 8-bit U and V color-difference samples from a 4-bit bus that carries them as time-multiplexed nibbles. It runs on the main pixel clock. Every group of four consecutive clocks carries one U sample and one V sample, with the halves interleaved. The order is U upper half, V lower half, V upper half, U lower half.

The block has no framing signal of its own, so it takes its phase from an in-band reference. While the vertical blanking input is high, the transmitter raises bit 0 of the bus as a sync pulse. The falling edge of that pulse marks the group boundary. Once the first such edge has been seen, the block reports itself locked. It then presents each completed U/V pair on parallel outputs with a one-clock valid strobe. During blanking the outputs are frozen and no strobe is issued.

Top module: `chroma_nibble_demux`

## Requirements
- R1: A synchronous active-high reset drives `valid`, `locked`, `u_out` and `v_out` to zero.
- R2: Until the first qualified sync edge after reset, `valid` stays low and `u_out`/`v_out` stay at zero, whatever arrives on the bus.
- R3: A qualified sync edge occurs when bit 0 of `nib` was 1 on one clock and is 0 on the next, with `vblank` high on that second clock. On that edge `locked` goes high. The nibble sampled on the following clock is taken as the U upper half.
- R4: With the four nibbles of a group sampled on successive clocks as n0, n1, n2, n3, the outputs are `u_out` = {n0, n3} and `v_out` = {n2, n1}.
- R5: `valid` goes high for exactly one clock, in the cycle after n3 is sampled, and `u_out`/`v_out` change only in that cycle. The strobe therefore repeats once every four clocks.
- R6: When `vblank` is high on the clock that samples n3, no strobe is produced and `u_out`/`v_out` hold their previous values.
- R7: A falling edge on bit 0 while `vblank` is low has no effect on the nibble phase.
- R8: A qualified sync edge in a later blanking interval realigns the phase, whatever the phase was before.
- R9: Once set, `locked` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| vblank | input | 1 | Vertical blanking; qualifies the bit-0 sync pulse and freezes the outputs |
| nib | input | NW (4) | Multiplexed chroma nibble bus |
| u_out | output | 2*NW (8) | Reassembled U sample |
| v_out | output | 2*NW (8) | Reassembled V sample |
| valid | output | 1 | One-clock strobe when a new U/V pair is presented |
| locked | output | 1 | High once a qualified sync edge has been seen |

## Verification
The hardest case to reach is a re-sync that moves the phase. The block has to be already locked on one alignment before a later blanking pulse shifts it. From the ports this needs a run of aligned groups, then a deliberate skew of one to three stray nibbles, then a fresh pulse of random width. The stimulus repeats that sequence several times with random skews, and checks the first groups after each pulse against bench-computed U/V values. Stray bit-0 falling edges outside blanking come both from random data and from one directed group. The outputs are checked to hold across blanking intervals.

// File: rtl/chroma_nibble_demux.sv
module chroma_nibble_demux #(
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vblank,
  input  logic [NW-1:0] nib,
  output logic [2*NW-1:0] u_out,
  output logic [2*NW-1:0] v_out,
  output logic          valid,
  output logic          locked
);
  localparam int SW = 2 * NW;

  logic          b0_q;
  logic [1:0]    ph;
  logic [NW-1:0] u_hi, v_lo, v_hi;

  wire sync_fall = vblank & b0_q & ~nib[0];
  wire emit      = (ph == 2'd3) & locked & ~vblank;

  always_ff @(posedge clk) begin
    if (rst) begin
      b0_q   <= 1'b0;
      ph     <= 2'd0;
      u_hi   <= '0;
      v_lo   <= '0;
      v_hi   <= '0;
      u_out  <= '0;
      v_out  <= '0;
      valid  <= 1'b0;
      locked <= 1'b0;
    end else begin
      b0_q  <= nib[0];
      valid <= 1'b0;
      if (sync_fall) begin
        ph     <= 2'd0;
        locked <= 1'b1;
      end else begin
        ph <= ph + 2'd1;
        case (ph)
          2'd0: u_hi <= nib;
          2'd1: v_lo <= nib;
          2'd2: v_hi <= nib;
          default: if (emit) begin
            u_out <= SW'({u_hi, nib});
            v_out <= SW'({v_hi, v_lo});
            valid <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/chroma_nibble_demux_chk.sv
module chroma_nibble_demux_chk #(
  parameter int NW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            vblank,
  input logic [2*NW-1:0] u_out,
  input logic [2*NW-1:0] v_out,
  input logic            valid,
  input logic            locked
);
  logic            armed;
  logic [2*NW-1:0] pu, pv;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
    pu <= u_out;
    pv <= v_out;
  end

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  a_r2_strobe_needs_lock: assert property (@(posedge clk) disable iff (rst)
    valid |-> locked);

  a_r6_no_strobe_in_blank: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(!vblank));

  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  a_r5_hold_between: assert property (@(posedge clk) disable iff (rst)
    (armed && !valid) |-> (u_out == pu && v_out == pv));
endmodule

bind chroma_nibble_demux chroma_nibble_demux_chk #(.NW(NW)) u_chk (
  .clk(clk), .rst(rst), .vblank(vblank), .u_out(u_out), .v_out(v_out),
  .valid(valid), .locked(locked)
);

// File: tb/chroma_nibble_demux_test.sv
module chroma_nibble_demux_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       vblank = 1'b0;
  logic [3:0] nib = 4'h0;
  logic [7:0] u_out, v_out;
  logic       valid, locked;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] last_u = 8'h00, last_v = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  chroma_nibble_demux uut (
    .clk(clk), .rst(rst), .vblank(vblank), .nib(nib),
    .u_out(u_out), .v_out(v_out), .valid(valid), .locked(locked)
  );

  function automatic logic [3:0] nib_of(input logic [7:0] u, input logic [7:0] v, input int k);
    case (k)
      0: return u[7:4];
      1: return v[3:0];
      2: return v[7:4];
      default: return u[3:0];
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_group(input logic [7:0] u, input logic [7:0] v,
                            input bit vb, input bit exp_valid, input string req);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      vblank = vb;
      nib = nib_of(u, v, k);
      @(posedge clk);
      #1;
      if (k < 3 || !exp_valid) begin
        check(valid == 1'b0, req, valid, 0);
        check(u_out == last_u && v_out == last_v, req, {u_out, v_out}, {last_u, last_v});
      end else begin
        check(valid == 1'b1, req, valid, 1);
        check(u_out == u && v_out == v, req, {u_out, v_out}, {u, v});
        last_u = u;
        last_v = v;
      end
    end
  endtask

  task automatic do_sync(input int width);
    @(negedge clk); vblank = 1'b1; nib = 4'h0;
    @(posedge clk); #1;
    check(valid == 1'b0, "R6", valid, 0);
    for (int i = 0; i < width; i++) begin
      @(negedge clk); nib = 4'h1;
      @(posedge clk); #1;
      check(valid == 1'b0 && u_out == last_u, "R6", valid, 0);
    end
    @(negedge clk); nib = 4'h0;
    @(posedge clk); #1;
    check(locked == 1'b1, "R3", locked, 1);
    check(valid == 1'b0 && v_out == last_v, "R6", valid, 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check(valid == 0 && locked == 0 && u_out == 0 && v_out == 0, "R1",
          {valid, locked, u_out, v_out}, 0);

    for (int i = 0; i < 3; i++)
      send_group(8'($urandom), 8'($urandom), 1'b0, 1'b0, "R2");
    check(locked == 1'b0, "R2", locked, 0);

    do_sync(2);
    send_group(8'hA5, 8'h3C, 1'b0, 1'b1, "R4");
    send_group(8'hFF, 8'h00, 1'b0, 1'b1, "R4");
    send_group(8'h00, 8'hFF, 1'b0, 1'b1, "R4");
    send_group(8'h10, 8'h00, 1'b0, 1'b1, "R7");
    for (int i = 0; i < 40; i++)
      send_group(8'($urandom), 8'($urandom), 1'b0, 1'b1, "R4");

    send_group(8'h62, 8'h9B, 1'b0, 1'b1, "R5");
    send_group(8'h4E, 8'hA8, 1'b1, 1'b0, "R6");
    send_group(8'h71, 8'h2D, 1'b0, 1'b1, "R6");

    for (int r = 0; r < 6; r++) begin
      int skew;
      skew = 1 + int'($urandom % 3);
      for (int s = 0; s < skew; s++) begin
        @(negedge clk); vblank = 1'b0; nib = 4'($urandom);
        @(posedge clk); #1;
        check(valid == 1'b0, "R8", valid, 0);
      end
      do_sync(1 + int'($urandom % 4));
      for (int g = 0; g < 5; g++)
        send_group(8'($urandom), 8'($urandom), 1'b0, 1'b1, "R8");
    end
    check(locked == 1'b1, "R9", locked, 1);

    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check(valid == 0 && locked == 0 && u_out == 0 && v_out == 0, "R1",
          {valid, locked, u_out, v_out}, 0);
    finish_run();
  end
endmodule